// File: doc/BRIEF.md
# Operating-System Timer with Match Channels and Watchdog

This block is a memory-mapped system timer. A 32-bit up-counter advances by one on every clock cycle in which the tick-enable strobe is high. Four 32-bit compare registers are checked against it. When the counter takes a value equal to one of them, that channel's status bit latches and its interrupt line rises, provided the channel's interrupt is enabled. Software clears a status bit by writing a one to it.

Compare channel 3 also serves as a watchdog. If the watchdog arm bit is set when channel 3 matches, the block raises a single-cycle system reset request and disarms itself. All registers sit on a simple 32-bit word bus. Reads are combinational. Writes take effect on the clock edge.

Top module: `ostm_timer`

## Requirements
- R1: After reset the counter, all four compare registers, the interrupt-enable register, the watchdog register, the status register, every irq line and the reset request are 0.
- R2: The counter (offset 0x10) increases by one on each clock edge where tick_en is 1, holds its value when tick_en is 0, and wraps from 0xFFFFFFFF to 0.
- R3: A bus write to offset 0x10 loads the written value, taking priority over a tick in the same cycle. Counting then continues from the loaded value.
- R4: Compare registers for channels 0, 1, 2 and 3 sit at offsets 0x00, 0x04, 0x08 and 0x0C. They are fully 32-bit writable and read back what was written.
- R5: A match occurs when the counter takes a new value (by tick or by load) equal to compare register n. If enable bit n is 1, status bit n (offset 0x14, bit n) and irq[n] become 1 on that same clock edge and stay 1 until cleared.
- R6: If enable bit n is 0 when a match occurs, status bit n and irq[n] stay 0, and they stay 0 when the enable is set afterwards.
- R7: A write to offset 0x14 clears exactly the status bits written as 1 and drops the matching irq lines. Bits written as 0 are untouched. If a match sets a bit in the same cycle that a write clears it, the bit ends up set.
- R8: The interrupt-enable register (offset 0x1C) stores bits 11:0 of a write, and bits 31:12 read back as 0. Bits 3:0 enable channels 0 to 3.
- R9: The watchdog register (offset 0x18) reads back the last 32-bit value written. When channel 3 matches while its bit 0 is 1, wdt_reset_req is 1 for exactly one cycle, starting at the edge where the counter takes the match value. The register then reads 0. This happens whatever the channel 3 enable bit is. With bit 0 clear, no request is made.
- R10: Reads from any offset other than the eight listed return 0, and writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance strobe |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 4 | Per-channel interrupt lines, equal to the status bits |
| wdt_reset_req | output | 1 | Single-cycle system reset request |

## Verification
A corrupted counter shows up on the very next read of offset 0x10. It also shows up as an interrupt that arrives one tick early or late, or not at all, and the bench samples that edge exactly. A status bit that fails to latch, latches without its enable, or resists a clear is visible both on irq and at offset 0x14 in the cycle after the event. A watchdog that fails to disarm shows up as a second reset pulse on the next match, or as a nonzero readback of offset 0x18.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
  localparam int DW    = 32;
  localparam int AW    = 8;
  localparam int NCH   = 4;
  localparam int IEN_W = 12;

  localparam logic [AW-1:0] OFS_CNT  = 8'h10;
  localparam logic [AW-1:0] OFS_STAT = 8'h14;
  localparam logic [AW-1:0] OFS_WDOG = 8'h18;
  localparam logic [AW-1:0] OFS_IEN  = 8'h1C;

  typedef struct packed {
    logic          cnt;
    logic          stat;
    logic          wdog;
    logic          ien;
    logic [NCH-1:0] cmp;
  } wr_sel_t;

  function automatic logic [DW-1:0] count_next(input logic [DW-1:0] cur,
                                               input logic load,
                                               input logic [DW-1:0] ld_val,
                                               input logic tick);
    if (load)      return ld_val;
    else if (tick) return cur + 1'b1;
    else           return cur;
  endfunction

  function automatic logic sticky_next(input logic cur, input logic clr,
                                       input logic set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/ostm_counter.sv
module ostm_counter
  import ostm_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         cnt_upd
);
  assign cnt_upd = load | tick;

  always_comb begin
    if (load)      cnt_nxt = ld_val;
    else if (tick) cnt_nxt = cnt_q + 1'b1;
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/ostm_chan.sv
module ostm_chan
  import ostm_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt_nxt,
  input  logic         cnt_upd,
  input  logic         enable,
  input  logic         clr,
  output logic [W-1:0] cmp_q,
  output logic         hit,
  output logic         status_q
);
  logic set_evt;

  assign hit     = cnt_upd && (cnt_nxt == cmp_q);
  assign set_evt = hit & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= wdata;
      status_q <= sticky_next(status_q, clr, set_evt);
    end
  end
endmodule

// File: rtl/ostm_wdog.sv
module ostm_wdog
  import ostm_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         ch3_hit,
  output logic [W-1:0] arm_q,
  output logic         req_q
);
  logic fire;

  assign fire = ch3_hit & arm_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= fire;
      if (fire)    arm_q <= '0;
      else if (we) arm_q <= wdata;
    end
  end
endmodule

// File: rtl/ostm_busdec.sv
module ostm_busdec
  import ostm_pkg::*;
(
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           cnt_q,
  input  logic [NCH-1:0][DW-1:0]  cmp_q,
  input  logic [NCH-1:0]          status_q,
  input  logic [DW-1:0]           wdog_q,
  input  logic [IEN_W-1:0]        ien_q,
  output wr_sel_t                 wsel,
  output logic [DW-1:0]           rdata
);
  localparam int IDX_W = AW - 2;

  logic [IDX_W-1:0] widx;
  logic             aligned;
  logic             in_cmp;

  assign widx    = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign in_cmp  = aligned && (widx < IDX_W'(NCH));

  always_comb begin
    wsel      = '0;
    wsel.cnt  = wr && (addr == OFS_CNT);
    wsel.stat = wr && (addr == OFS_STAT);
    wsel.wdog = wr && (addr == OFS_WDOG);
    wsel.ien  = wr && (addr == OFS_IEN);
    for (int n = 0; n < NCH; n++)
      wsel.cmp[n] = wr && in_cmp && (widx == IDX_W'(n));
  end

  always_comb begin
    rdata = '0;
    if (in_cmp) begin
      for (int n = 0; n < NCH; n++)
        if (widx == IDX_W'(n)) rdata = cmp_q[n];
    end else begin
      case (addr)
        OFS_CNT:  rdata = cnt_q;
        OFS_STAT: rdata = DW'(status_q);
        OFS_WDOG: rdata = wdog_q;
        OFS_IEN:  rdata = DW'(ien_q);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ostm_timer.sv
module ostm_timer
  import ostm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [7:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [3:0]    irq,
  output logic          wdt_reset_req
);
  localparam int WDOG_CH = 3;

  wr_sel_t               wsel;
  logic [DW-1:0]         cnt_q;
  logic [DW-1:0]         cnt_nxt;
  logic                  cnt_upd;
  logic                  cnt_load;
  logic [NCH-1:0][DW-1:0] cmp_q;
  logic [NCH-1:0]        hit_vec;
  logic [NCH-1:0]        status_q;
  logic [NCH-1:0]        clr_vec;
  logic [IEN_W-1:0]      ien_q;
  logic [DW-1:0]         wdog_q;

  assign cnt_load = wsel.cnt;
  assign clr_vec  = wsel.stat ? bus_wdata[NCH-1:0] : '0;

  ostm_busdec u_dec (
    .wr       (bus_wr),
    .addr     (bus_addr),
    .cnt_q    (cnt_q),
    .cmp_q    (cmp_q),
    .status_q (status_q),
    .wdog_q   (wdog_q),
    .ien_q    (ien_q),
    .wsel     (wsel),
    .rdata    (bus_rdata)
  );

  ostm_counter #(.W(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en),
    .load    (cnt_load),
    .ld_val  (bus_wdata),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .cnt_upd (cnt_upd)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ostm_chan #(.W(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_we   (wsel.cmp[n]),
      .wdata    (bus_wdata),
      .cnt_nxt  (cnt_nxt),
      .cnt_upd  (cnt_upd),
      .enable   (ien_q[n]),
      .clr      (clr_vec[n]),
      .cmp_q    (cmp_q[n]),
      .hit      (hit_vec[n]),
      .status_q (status_q[n])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ien_q <= '0;
    else if (wsel.ien) ien_q <= bus_wdata[IEN_W-1:0];
  end

  ostm_wdog #(.W(DW)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wsel.wdog),
    .wdata   (bus_wdata),
    .ch3_hit (hit_vec[WDOG_CH]),
    .arm_q   (wdog_q),
    .req_q   (wdt_reset_req)
  );

  assign irq = status_q;
endmodule

// File: rtl/ostm_timer_chk.sv
module ostm_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic [31:0] cnt,
  input logic        cnt_load,
  input logic [3:0]  hit,
  input logic [11:0] ien,
  input logic [3:0]  status,
  input logic [3:0]  clr,
  input logic [3:0]  irq,
  input logic [31:0] wdog,
  input logic        req
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !cnt_load |=> cnt == $past(cnt) + 32'd1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !cnt_load |=> $stable(cnt)); // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req); // R9
  AST_REQ_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> wdog == 32'd0); // R9

  for (genvar n = 0; n < 4; n++) begin : g_a
    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      hit[n] && ien[n] |=> status[n] && irq[n]); // R5
    AST_NO_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
      !status[n] && !(hit[n] && ien[n]) |=> !irq[n]); // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      status[n] && clr[n] && !(hit[n] && ien[n]) |=> !irq[n]); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      status[n] && !clr[n] |=> irq[n]); // R5
  end
endmodule

bind ostm_timer ostm_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .cnt      (cnt_q),
  .cnt_load (cnt_load),
  .hit      (hit_vec),
  .ien      (ien_q),
  .status   (status_q),
  .clr      (clr_vec),
  .irq      (irq),
  .wdog     (wdog_q),
  .req      (wdt_reset_req)
);

// File: tb/sim_ostm_timer.sv
`timescale 1ns/1ps
module sim_ostm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  logic        wdt_reset_req;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  ostm_timer u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic ticks(input int k);
    tick_en = 1'b1;
    repeat (k) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8'h20; a += 4) begin
      rd(8'(a), v); check("R1", v, 32'h0);
    end
    check("R1 irq", {28'h0, irq}, 32'h0);
    check("R1 req", {31'h0, wdt_reset_req}, 32'h0);

    // R4 compare registers
    for (int n = 0; n < 4; n++) begin
      pat = 32'hA5000000 ^ (32'h01010101 << n) ^ 32'(n * 7);
      wr(8'(n * 4), pat);
      rd(8'(n * 4), v); check("R4", v, pat);
    end

    // R2 counting, hold, wrap; R3 load
    wr(8'h10, 32'hFFFF_FFFE);
    rd(8'h10, v); check("R3 load", v, 32'hFFFF_FFFE);
    ticks(1); rd(8'h10, v); check("R2 step", v, 32'hFFFF_FFFF);
    ticks(1); rd(8'h10, v); check("R2 wrap", v, 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h10, v); check("R2 hold", v, 32'h0);
    ticks(5); rd(8'h10, v); check("R2 count", v, 32'd5);
    // load wins over tick in same cycle
    @(negedge clk);
    tick_en = 1'b1; bus_addr = 8'h10; bus_wdata = 32'd1000; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(8'h10, v); check("R3 priority", v, 32'd1000);
    @(negedge clk); tick_en = 1'b0;
    rd(8'h10, v); check("R3 continue", v, 32'd1001);

    // R8 enable width
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, v); check("R8", v, 32'h0000_0FFF);
    wr(8'h1C, 32'h0);

    // R5 / R6 sweep over channels and enable state
    for (int n = 0; n < 4; n++) begin
      for (int en = 0; en < 2; en++) begin
        wr(8'h1C, 32'h0);
        wr(8'h10, 32'd100);
        wr(8'(n * 4), 32'd103);
        wr(8'h14, 32'hF);
        wr(8'h1C, en ? (32'h1 << n) : 32'h0);
        ticks(2);
        check("R5 early", {28'h0, irq}, 32'h0);
        ticks(1);
        check(en ? "R5 irq" : "R6 irq", {28'h0, irq}, en ? (32'h1 << n) : 32'h0);
        rd(8'h14, v);
        check(en ? "R5 status" : "R6 status", v, en ? (32'h1 << n) : 32'h0);
        ticks(4);
        check(en ? "R5 sticky" : "R6 stays", {28'h0, irq}, en ? (32'h1 << n) : 32'h0);
        wr(8'h1C, 32'h1 << n);
        check("R6 late enable", {28'h0, irq}, en ? (32'h1 << n) : 32'h0);
        wr(8'h14, 32'h1 << n);
        check("R7 clear", {28'h0, irq}, 32'h0);
      end
    end

    // R7 selective clear
    wr(8'h1C, 32'h3);
    wr(8'h00, 32'd301);
    wr(8'h04, 32'd302);
    wr(8'h10, 32'd300);
    ticks(2);
    check("R7 both set", {28'h0, irq}, 32'h3);
    wr(8'h14, 32'h1);
    rd(8'h14, v); check("R7 partial", v, 32'h2);
    wr(8'h14, 32'hC);
    rd(8'h14, v); check("R7 unset bits", v, 32'h2);
    wr(8'h14, 32'hF);
    // R7 match wins over clear
    wr(8'h10, 32'd300);
    @(negedge clk);
    tick_en = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    rd(8'h14, v); check("R7 match wins", v, 32'h1);
    wr(8'h14, 32'hF);
    wr(8'h1C, 32'h0);

    // R9 watchdog
    wr(8'h18, 32'h1234_5671);
    rd(8'h18, v); check("R9 readback", v, 32'h1234_5671);
    wr(8'h0C, 32'd502);
    wr(8'h10, 32'd500);
    tick_en = 1'b1;
    @(negedge clk);
    check("R9 no early req", {31'h0, wdt_reset_req}, 32'h0);
    @(negedge clk);
    tick_en = 1'b0;
    check("R9 req", {31'h0, wdt_reset_req}, 32'h1);
    check("R9 irq3 off", {28'h0, irq}, 32'h0);
    @(negedge clk);
    check("R9 one cycle", {31'h0, wdt_reset_req}, 32'h0);
    rd(8'h18, v); check("R9 disarmed", v, 32'h0);
    wr(8'h18, 32'hFFFF_FFFE);
    wr(8'h10, 32'd501);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    check("R9 bit0 clear", {31'h0, wdt_reset_req}, 32'h0);
    rd(8'h18, v); check("R9 kept", v, 32'hFFFF_FFFE);

    // R10 undefined offsets
    wr(8'h10, 32'd77);
    wr(8'h20, 32'hDEAD_BEEF);
    wr(8'h40, 32'hDEAD_BEEF);
    wr(8'h02, 32'hDEAD_BEEF);
    wr(8'hFC, 32'hDEAD_BEEF);
    rd(8'h20, v); check("R10 read", v, 32'h0);
    rd(8'hFC, v); check("R10 read", v, 32'h0);
    rd(8'h02, v); check("R10 read", v, 32'h0);
    rd(8'h00, v); check("R10 cmp0", v, 32'd301);
    rd(8'h10, v); check("R10 cnt", v, 32'd77);
    rd(8'h14, v); check("R10 status", v, 32'h0);
    rd(8'h18, v); check("R10 wdog", v, 32'hFFFF_FFFE);
    rd(8'h1C, v); check("R10 ien", v, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule